// File: doc/BRIEF.md
# Serial Port Status Register with Read-Before-Clear Flags

This block holds the 16-bit status word of an asynchronous serial port that has a receive FIFO. Event pulses from the transmitter, the receiver and the FIFO logic raise sticky flags. Software reads these flags and writes the word back over a simple strobe bus. A sticky flag only falls when software writes 0 to it after a read has returned that flag as 1. A write of 1 never raises a flag. Three bits are not held here: they show live hardware levels and ignore writes.

The block also detects receive overrun. The overrun flag is raised when a character completes while the receive FIFO is already full. The block then blocks the FIFO push for that character and for every later character. Receive stays inhibited until software clears the overrun flag through the same read-then-write sequence.

Top module: `sersta_reg`

## Requirements
- R1: After reset (`rst_n` low), every held flag is 0 except transmit-FIFO-empty (bit 5), which is 1. With `lv_tend`=1, `lv_fer`=0 and `lv_per`=0, `stat_q` reads 16'h0060 and `rx_inhibit` is 0.
- R2: Bits 15 to 10 of `stat_q` always read 0, whatever is written.
- R3: An event pulse in one cycle shows its flag as 1 in `stat_q` after that clock edge. The pulses map to bits as follows: `ev_tsf` to bit 8, `ev_rxerr` to bit 7, `ev_tdfe` to bit 5, `ev_brk` to bit 4, `ev_rdf` to bit 1 and `ev_dr` to bit 0. Writing 1 to any bit never sets it.
- R4: Writing 0 to a set flag that has not been read as 1 since it was last set leaves the flag at 1.
- R5: After a read (`rd_en`) returns a flag as 1, a write (`wr_en`) with that bit at 0 clears only that flag. Bits written as 1 keep their value.
- R6: A new set event on a flag cancels any earlier read of it, so a fresh read is needed before a 0 write clears it.
- R7: If a set event and a qualifying 0 write hit the same flag in the same cycle, the flag stays 1.
- R8: Bit 6 follows `lv_tend`, bit 3 follows `lv_fer` and bit 2 follows `lv_per` in the same cycle. Bus writes have no effect on these bits.
- R9: When `rx_char_done`, `rx_en` and `rx_fifo_full` are all high, `fifo_push` stays 0 in that cycle and the overrun flag (bit 9) reads 1 after the edge. With the FIFO not full, `fifo_push` follows the completed character.
- R10: While bit 9 is 1, `rx_inhibit` is 1 and `fifo_push` stays 0 for every completed character. Once the flag is cleared, pushes resume.
- R11: Deasserting `rx_en` leaves the overrun flag unchanged.
- R12: A high level on `man_rst` at a clock edge returns all held flags, including overrun, to their reset values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low power-on reset |
| man_rst | input | 1 | Synchronous manual reset, active high |
| ev_tsf | input | 1 | Transmit-shift event pulse |
| ev_rxerr | input | 1 | Receive-error event pulse |
| ev_tdfe | input | 1 | Transmit-FIFO-empty event pulse |
| ev_brk | input | 1 | Break-detected event pulse |
| ev_rdf | input | 1 | Receive-FIFO-full-threshold event pulse |
| ev_dr | input | 1 | Receive-data-ready event pulse |
| lv_tend | input | 1 | Live transmit-end level |
| lv_fer | input | 1 | Live framing-error level |
| lv_per | input | 1 | Live parity-error level |
| rx_en | input | 1 | Receiver enable |
| rx_char_done | input | 1 | Pulse: one serial character finished |
| rx_fifo_full | input | 1 | Receive FIFO has no free entry |
| rd_en | input | 1 | Bus read strobe for the status word |
| wr_en | input | 1 | Bus write strobe |
| wr_data | input | 16 | Bus write data |
| stat_q | output | 16 | Status word |
| fifo_push | output | 1 | Store the completed character into the FIFO |
| rx_inhibit | output | 1 | Receiver stalled by overrun |

## Verification
The properties assume that the event inputs are single-cycle pulses. They also assume that `rx_char_done` is only meaningful when sampled at a clock edge, and that the live level inputs are stable across each edge. The stimulus drives every input on the falling clock edge and holds it for exactly one rising edge. Each bus access is a single strobe cycle, and a read and a write never overlap. The only exception is the set-versus-clear race in R7, where an event pulse and a write share a cycle on purpose.

// File: rtl/sersta_pkg.sv
// Package: bit positions and masks of the serial status word.
// Assumes a 16-bit word. Neighbouring logic decodes the flag positions,
// so they are fixed here.
package sersta_pkg;
    localparam int REG_W   = 16;
    localparam int B_OVR   = 9;
    localparam int B_TSF   = 8;
    localparam int B_RXERR = 7;
    localparam int B_TEND  = 6;
    localparam int B_TDFE  = 5;
    localparam int B_BRK   = 4;
    localparam int B_FER   = 3;
    localparam int B_PER   = 2;
    localparam int B_RDF   = 1;
    localparam int B_DR    = 0;

    // Flags held in flops and cleared by software
    localparam logic [REG_W-1:0] CLR_MASK = (1 << B_OVR) | (1 << B_TSF) | (1 << B_RXERR)
                                          | (1 << B_TDFE) | (1 << B_BRK) | (1 << B_RDF)
                                          | (1 << B_DR);
    // Bits that mirror live hardware levels
    localparam logic [REG_W-1:0] RO_MASK  = (1 << B_TEND) | (1 << B_FER) | (1 << B_PER);
    // Reset value of held flags
    localparam logic [REG_W-1:0] RST_MASK = (1 << B_TDFE);
endpackage

// File: rtl/sersta_clrflag.sv
// One sticky status flag with a hidden "seen" bit.
// Hardware sets the flag. Software clears it by writing 0, but only after
// a read has returned the flag as 1 since it was last set.
// Assumes rd_hit and wr_zero come from single-cycle bus strobes.
module sersta_clrflag #(
    parameter logic RST_VAL = 1'b0
) (
    input  logic clk,
    input  logic rst_n,
    input  logic mrst,
    input  logic set_ev,
    input  logic rd_hit,
    input  logic wr_zero,
    output logic flag_q
);
    logic seen_q;

    // Flag and seen-bit update; a set event beats a clear in the same cycle
    always_ff @(posedge clk) begin
        if (!rst_n || mrst) begin
            flag_q <= RST_VAL;
            seen_q <= 1'b0;
        end else if (set_ev) begin
            flag_q <= 1'b1;
            seen_q <= 1'b0;
        end else if (wr_zero && seen_q) begin
            flag_q <= 1'b0;
            seen_q <= 1'b0;
        end else if (rd_hit && flag_q) begin
            seen_q <= 1'b1;
        end
    end
endmodule

// File: rtl/sersta_ovrdet.sv
// Overrun detector for the receive path.
// Raises an overrun set request when a character completes against a full
// FIFO. It blocks the FIFO push while overrun is pending or active.
// Assumes rx_done is a one-cycle pulse per character.
module sersta_ovrdet (
    input  logic rx_done,
    input  logic rx_en,
    input  logic fifo_full,
    input  logic ovr_q,
    output logic ovr_set,
    output logic push
);
    logic char_ok;

    // Decide whether the completed character is stored or causes overrun
    always_comb begin
        char_ok = rx_done && rx_en && !ovr_q;
        ovr_set = char_ok && fifo_full;
        push    = char_ok && !fifo_full;
    end
endmodule

// File: rtl/sersta_reg.sv
// Serial port status register.
// Puts together the sticky flags, the live level bits and the overrun
// stall. Reserved bits read as 0. Assumes reads and writes are
// single-cycle strobes.
module sersta_reg
    import sersta_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             man_rst,
    input  logic             ev_tsf,
    input  logic             ev_rxerr,
    input  logic             ev_tdfe,
    input  logic             ev_brk,
    input  logic             ev_rdf,
    input  logic             ev_dr,
    input  logic             lv_tend,
    input  logic             lv_fer,
    input  logic             lv_per,
    input  logic             rx_en,
    input  logic             rx_char_done,
    input  logic             rx_fifo_full,
    input  logic             rd_en,
    input  logic             wr_en,
    input  logic [REG_W-1:0] wr_data,
    output logic [REG_W-1:0] stat_q,
    output logic             fifo_push,
    output logic             rx_inhibit
);
    logic [REG_W-1:0] set_vec;
    logic [REG_W-1:0] ro_vec;
    logic             ovr_set;

    // Gather the set events and live levels at their bit positions
    always_comb begin
        set_vec          = '0;
        set_vec[B_OVR]   = ovr_set;
        set_vec[B_TSF]   = ev_tsf;
        set_vec[B_RXERR] = ev_rxerr;
        set_vec[B_TDFE]  = ev_tdfe;
        set_vec[B_BRK]   = ev_brk;
        set_vec[B_RDF]   = ev_rdf;
        set_vec[B_DR]    = ev_dr;
        ro_vec           = '0;
        ro_vec[B_TEND]   = lv_tend;
        ro_vec[B_FER]    = lv_fer;
        ro_vec[B_PER]    = lv_per;
    end

    // Overrun detection and FIFO push gating
    sersta_ovrdet u_ovr (
        .rx_done   (rx_char_done),
        .rx_en     (rx_en),
        .fifo_full (rx_fifo_full),
        .ovr_q     (stat_q[B_OVR]),
        .ovr_set   (ovr_set),
        .push      (fifo_push)
    );

    // Build each bit as a sticky flag, a live level or a constant 0
    for (genvar i = 0; i < REG_W; i++) begin : g_bit
        if (CLR_MASK[i]) begin : g_clr
            sersta_clrflag #(.RST_VAL(RST_MASK[i])) u_flag (
                .clk     (clk),
                .rst_n   (rst_n),
                .mrst    (man_rst),
                .set_ev  (set_vec[i]),
                .rd_hit  (rd_en),
                .wr_zero (wr_en && !wr_data[i]),
                .flag_q  (stat_q[i])
            );
        end else if (RO_MASK[i]) begin : g_ro
            assign stat_q[i] = ro_vec[i];
        end else begin : g_rsv
            assign stat_q[i] = 1'b0;
        end
    end

    assign rx_inhibit = stat_q[B_OVR];
endmodule

// File: rtl/sersta_reg_chk.sv
// Checker for sersta_reg, attached with bind.
// Assumes single-cycle event pulses and strobes.
module sersta_reg_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        man_rst,
    input logic        ev_dr,
    input logic        lv_tend,
    input logic        rx_en,
    input logic        rx_char_done,
    input logic        rx_fifo_full,
    input logic        wr_en,
    input logic [15:0] wr_data,
    input logic [15:0] stat_q,
    input logic        fifo_push,
    input logic        rx_inhibit
);
    // R2
    reserved_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        stat_q[15:10] == 6'd0);

    // R3
    dr_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ev_dr && !man_rst) |=> stat_q[0]);

    // R4
    dr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (stat_q[0] && !man_rst && !(wr_en && !wr_data[0])) |=> stat_q[0]);

    // R8
    tend_live_chk: assert property (@(posedge clk) disable iff (!rst_n)
        stat_q[6] == lv_tend);

    // R9
    ovr_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_char_done && rx_en && rx_fifo_full && !man_rst) |=> stat_q[9]);

    // R10
    ovr_stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rx_inhibit |-> !fifo_push);

    // R11
    ovr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (stat_q[9] && !man_rst && !(wr_en && !wr_data[9])) |=> stat_q[9]);

    // R12
    mrst_chk: assert property (@(posedge clk) disable iff (!rst_n)
        man_rst |=> (stat_q[9:7] == 3'b000));
endmodule

bind sersta_reg sersta_reg_chk u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .man_rst      (man_rst),
    .ev_dr        (ev_dr),
    .lv_tend      (lv_tend),
    .rx_en        (rx_en),
    .rx_char_done (rx_char_done),
    .rx_fifo_full (rx_fifo_full),
    .wr_en        (wr_en),
    .wr_data      (wr_data),
    .stat_q       (stat_q),
    .fifo_push    (fifo_push),
    .rx_inhibit   (rx_inhibit)
);

// File: tb/sim_sersta_reg.sv
module sim_sersta_reg;
    localparam time CLK_PERIOD = 10ns;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        man_rst = 1'b0;
    logic        ev_tsf = 1'b0, ev_rxerr = 1'b0, ev_tdfe = 1'b0;
    logic        ev_brk = 1'b0, ev_rdf = 1'b0, ev_dr = 1'b0;
    logic        lv_tend = 1'b1, lv_fer = 1'b0, lv_per = 1'b0;
    logic        rx_en = 1'b0, rx_char_done = 1'b0, rx_fifo_full = 1'b0;
    logic        rd_en = 1'b0, wr_en = 1'b0;
    logic [15:0] wr_data = '0;
    logic [15:0] stat_q;
    logic        fifo_push, rx_inhibit;

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    sersta_reg u0 (
        .clk(clk), .rst_n(rst_n), .man_rst(man_rst),
        .ev_tsf(ev_tsf), .ev_rxerr(ev_rxerr), .ev_tdfe(ev_tdfe),
        .ev_brk(ev_brk), .ev_rdf(ev_rdf), .ev_dr(ev_dr),
        .lv_tend(lv_tend), .lv_fer(lv_fer), .lv_per(lv_per),
        .rx_en(rx_en), .rx_char_done(rx_char_done), .rx_fifo_full(rx_fifo_full),
        .rd_en(rd_en), .wr_en(wr_en), .wr_data(wr_data),
        .stat_q(stat_q), .fifo_push(fifo_push), .rx_inhibit(rx_inhibit)
    );

    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic bus_rd();
        rd_en = 1'b1; step(); rd_en = 1'b0;
    endtask

    task automatic bus_wr(input logic [15:0] d);
        wr_en = 1'b1; wr_data = d; step(); wr_en = 1'b0; wr_data = '0;
    endtask

    task automatic t_reset();
        check("R1 reset word", stat_q, 16'h0060);
        check("R1 inhibit", {15'd0, rx_inhibit}, 16'd0);
    endtask

    task automatic t_reserved_and_ones();
        bus_wr(16'hFFFF);
        check("R2/R3 write ones", stat_q, 16'h0060);
        bus_wr(16'h0000);
        check("R4 zero without read", stat_q, 16'h0060);
    endtask

    task automatic t_set_clear();
        ev_dr = 1'b1; step(); ev_dr = 1'b0;
        check("R3 dr set", stat_q, 16'h0061);
        bus_wr(16'h0000);
        check("R4 dr kept", stat_q, 16'h0061);
        bus_rd();
        bus_wr(16'hFFFE);
        check("R5 dr cleared only", stat_q, 16'h0060);
        bus_wr(16'hFFDF);
        check("R5 tdfe cleared", stat_q, 16'h0040);
        ev_tsf = 1'b1; ev_rxerr = 1'b1; step(); ev_tsf = 1'b0; ev_rxerr = 1'b0;
        check("R3 tsf rxerr set", stat_q, 16'h01C0);
        bus_rd();
        bus_wr(16'h0000);
        check("R5 tsf rxerr cleared", stat_q, 16'h0040);
    endtask

    task automatic t_rearm();
        ev_brk = 1'b1; step(); ev_brk = 1'b0;
        check("R3 brk set", stat_q, 16'h0050);
        bus_rd();
        ev_brk = 1'b1; step(); ev_brk = 1'b0;
        bus_wr(16'h0000);
        check("R6 brk needs new read", stat_q, 16'h0050);
        bus_rd();
        bus_wr(16'h0000);
        check("R6 brk cleared", stat_q, 16'h0040);
    endtask

    task automatic t_race();
        ev_rdf = 1'b1; step(); ev_rdf = 1'b0;
        check("R3 rdf set", stat_q, 16'h0042);
        bus_rd();
        ev_rdf = 1'b1; wr_en = 1'b1; wr_data = 16'h0000;
        step();
        ev_rdf = 1'b0; wr_en = 1'b0;
        check("R7 set wins", stat_q, 16'h0042);
        bus_rd();
        bus_wr(16'h0000);
        check("R7 later clear", stat_q, 16'h0040);
    endtask

    task automatic t_readonly();
        lv_tend = 1'b0; lv_fer = 1'b1; lv_per = 1'b1;
        step();
        check("R8 live levels", stat_q, 16'h000C);
        bus_rd();
        bus_wr(16'h0000);
        check("R8 zero write ignored", stat_q, 16'h000C);
        bus_wr(16'hFFFF);
        check("R8 ones write ignored", stat_q, 16'h000C);
        lv_tend = 1'b1; lv_fer = 1'b0; lv_per = 1'b0;
        step();
        check("R8 levels restored", stat_q, 16'h0040);
    endtask

    task automatic t_overrun();
        rx_en = 1'b1; rx_char_done = 1'b1; rx_fifo_full = 1'b0;
        #1;
        check("R9 push when room", {15'd0, fifo_push}, 16'd1);
        step();
        rx_fifo_full = 1'b1;
        #1;
        check("R9 no push when full", {15'd0, fifo_push}, 16'd0);
        step();
        rx_char_done = 1'b0;
        check("R9 overrun set", stat_q, 16'h0240);
        check("R10 inhibit", {15'd0, rx_inhibit}, 16'd1);
        rx_fifo_full = 1'b0; rx_char_done = 1'b1;
        #1;
        check("R10 push blocked", {15'd0, fifo_push}, 16'd0);
        step();
        rx_char_done = 1'b0; rx_en = 1'b0;
        step();
        check("R11 rx_en off keeps overrun", stat_q, 16'h0240);
        bus_rd();
        bus_wr(16'hFDFF);
        check("R10 overrun cleared", stat_q, 16'h0040);
        rx_en = 1'b1; rx_char_done = 1'b1;
        #1;
        check("R10 push resumes", {15'd0, fifo_push}, 16'd1);
        step();
        rx_char_done = 1'b0;
    endtask

    task automatic t_manual_reset();
        rx_fifo_full = 1'b1; rx_char_done = 1'b1; ev_tsf = 1'b1;
        step();
        rx_char_done = 1'b0; ev_tsf = 1'b0; rx_fifo_full = 1'b0;
        check("R9 overrun again", stat_q, 16'h0340);
        man_rst = 1'b1; step(); man_rst = 1'b0;
        check("R12 manual reset", stat_q, 16'h0060);
        check("R12 inhibit off", {15'd0, rx_inhibit}, 16'd0);
    endtask

    initial begin
        @(negedge clk);
        step();
        rst_n = 1'b1;
        step();
        t_reset();
        t_reserved_and_ones();
        t_set_clear();
        t_rearm();
        t_race();
        t_readonly();
        t_overrun();
        t_manual_reset();
        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 5000);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end
endmodule